// File: doc/BRIEF.md
# Registered Narrow-to-Wide Bus Exchanger

This block moves data between a 12-bit narrow port (A) and a 24-bit wide port (B) that is split into two 12-bit halves, the upper-lane B1 and the lower-lane B2. Going from narrow to wide, two narrow words taken from A on separate clock edges come out together as one wide word on B. Going from wide to narrow, each B half is captured into its own register, and a registered select decides which of the two captured halves drives A.

Every storage element updates on the rising clock edge, and only while its own active-low clock enable is low. The B1 path has two register stages. The second stage shares its enable with the single B2 register. As a result, a word loaded into the B1 front stage moves out to B1 on the same edge that a new word lands on B2. Both active-low output enables are registered, so each port's drive turns on or off only at a clock edge. Each tri-state port is modelled as a data output plus a drive-enable output. A synchronous active-high reset is included for simulation.

Top module: `nw_bus_exchanger`

## Requirements
- R1: After any rising edge with `rst` high, `aDrive` and `bDrive` are 0, and `aOut`, `b1Out` and `b2Out` are 0 under either value of `selB2`, until a register is loaded again.
- R2: The B1 front stage loads `aIn` at an edge where `ceB1Neg` is 0. While `ceB1Neg` is 1 it holds.
- R3: At an edge where `ceB2Neg` is 0, `b2Out` takes `aIn` and `b1Out` takes the B1 front stage value held before that edge. While `ceB2Neg` is 1, `b1Out` and `b2Out` hold.
- R4: If word W1 is applied at an edge with only `ceB1Neg` low, and word W2 at the next edge with only `ceB2Neg` low, then after that second edge `b1Out` = W1 and `b2Out` = W2.
- R5: The B1-side capture register loads `b1In` at an edge where `ceA1Neg` is 0. The B2-side capture register loads `b2In` at an edge where `ceA2Neg` is 0. Each holds otherwise.
- R6: `selB2` is sampled at every edge. After an edge that sampled 0, `aOut` shows the B1-side capture register. After an edge that sampled 1, it shows the B2-side capture register. A change on `selB2` between edges does not change `aOut`.
- R7: After each edge, `aDrive` equals the inverse of `oeANeg` sampled at that edge, and `bDrive` equals the inverse of `oeBNeg` sampled at that edge.
- R8: While a drive-enable output is 0, the data outputs of that port still show their register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| aIn | input | 12 | Narrow-port input word |
| b1In | input | 12 | Wide-port upper-lane input |
| b2In | input | 12 | Wide-port lower-lane input |
| ceB1Neg | input | 1 | Active-low enable, B1 front stage |
| ceB2Neg | input | 1 | Active-low enable, B1 back stage and B2 register |
| ceA1Neg | input | 1 | Active-low enable, B1-side capture for A |
| ceA2Neg | input | 1 | Active-low enable, B2-side capture for A |
| selB2 | input | 1 | Select for A output: 0 picks B1 side, 1 picks B2 side |
| oeANeg | input | 1 | Active-low output enable for A, registered |
| oeBNeg | input | 1 | Active-low output enable for B, registered |
| aOut | output | 12 | Narrow-port output data |
| aDrive | output | 1 | A drive enable; 0 means high impedance |
| b1Out | output | 12 | Wide-port upper-lane output data |
| b2Out | output | 12 | Wide-port lower-lane output data |
| bDrive | output | 1 | B drive enable; 0 means high impedance |

## Verification
The bench sweeps all sixteen combinations of the four clock enables, with changing data, select and output-enable values, and compares every output against an arithmetic model after each edge. It targets the pairing sequence. A back stage wired to the wrong enable, or loaded from `aIn` instead of the front stage, would put W2 or a stale word on B1. It also checks that a mid-cycle change on select or output enable does not reach the outputs early; a combinational select would switch `aOut` before the edge. A reset applied in the middle of traffic must clear every lane and disable both drivers; a design that missed one register would leak an old word.

// File: rtl/xch_pkg.sv
package xch_pkg;

  // Strobes from control to datapath, all active high
  typedef struct packed {
    logic ldB1Front;  // B1 front stage load
    logic ldWide;     // B1 back stage and B2 register load
    logic ldA1;       // B1-side capture load
    logic ldA2;       // B2-side capture load
    logic selB2;      // registered select
    logic driveA;     // registered A drive enable
    logic driveB;     // registered B drive enable
  } xch_strobe_t;

endpackage

// File: rtl/xch_reg.sv
module xch_reg #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end

endmodule

// File: rtl/xch_ctrl.sv
module xch_ctrl
  import xch_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        ceB1Neg,
  input  logic        ceB2Neg,
  input  logic        ceA1Neg,
  input  logic        ceA2Neg,
  input  logic        selB2,
  input  logic        oeANeg,
  input  logic        oeBNeg,
  output xch_strobe_t strobe
);

  logic selReg;
  logic oeAReg;
  logic oeBReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      selReg <= 1'b0;
      oeAReg <= 1'b1;
      oeBReg <= 1'b1;
    end else begin
      selReg <= selB2;
      oeAReg <= oeANeg;
      oeBReg <= oeBNeg;
    end
  end

  always_comb begin
    strobe.ldB1Front = ~ceB1Neg;
    strobe.ldWide    = ~ceB2Neg;
    strobe.ldA1      = ~ceA1Neg;
    strobe.ldA2      = ~ceA2Neg;
    strobe.selB2     = selReg;
    strobe.driveA    = ~oeAReg;
    strobe.driveB    = ~oeBReg;
  end

  // R1: reset disables both drivers
  a_r1_reset_off: assert property (@(posedge clk) rst |=> (!strobe.driveA && !strobe.driveB));

  // R7: drive enables follow the sampled output enables one edge later
  a_r7_drive_a: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (strobe.driveA == !$past(oeANeg)));
  a_r7_drive_b: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (strobe.driveB == !$past(oeBNeg)));

  // R6: select is taken at the edge
  a_r6_sel_reg: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (strobe.selB2 == $past(selB2)));

endmodule

// File: rtl/xch_datapath.sv
module xch_datapath
  import xch_pkg::*;
#(
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  xch_strobe_t       strobe,
  input  logic [WORD_W-1:0] aIn,
  input  logic [WORD_W-1:0] b1In,
  input  logic [WORD_W-1:0] b2In,
  output logic [WORD_W-1:0] aOut,
  output logic [WORD_W-1:0] b1Out,
  output logic [WORD_W-1:0] b2Out
);

  localparam int LANES = 2;

  logic [WORD_W-1:0] b1Front;
  logic [WORD_W-1:0] capIn   [LANES];
  logic [WORD_W-1:0] capQ    [LANES];
  logic              capLoad [LANES];

  // Narrow-to-wide: B1 has two stages, B2 has one
  xch_reg #(.W(WORD_W)) uB1Front (
    .clk(clk), .rst(rst), .load(strobe.ldB1Front), .d(aIn), .q(b1Front)
  );
  xch_reg #(.W(WORD_W)) uB1Back (
    .clk(clk), .rst(rst), .load(strobe.ldWide), .d(b1Front), .q(b1Out)
  );
  xch_reg #(.W(WORD_W)) uB2 (
    .clk(clk), .rst(rst), .load(strobe.ldWide), .d(aIn), .q(b2Out)
  );

  // Wide-to-narrow: one capture register per B lane
  always_comb begin
    capIn[0]   = b1In;
    capIn[1]   = b2In;
    capLoad[0] = strobe.ldA1;
    capLoad[1] = strobe.ldA2;
  end

  for (genvar g = 0; g < LANES; g++) begin : gCap
    xch_reg #(.W(WORD_W)) uCap (
      .clk(clk), .rst(rst), .load(capLoad[g]), .d(capIn[g]), .q(capQ[g])
    );
  end

  assign aOut = strobe.selB2 ? capQ[1] : capQ[0];

  // R2: front stage captures the narrow word
  a_r2_front_load: assert property (@(posedge clk) disable iff (rst)
    strobe.ldB1Front |=> (b1Front == $past(aIn)));

  // R3: wide load shifts front to B1 and takes A to B2
  a_r3_wide_shift: assert property (@(posedge clk) disable iff (rst)
    strobe.ldWide |=> (b1Out == $past(b1Front) && b2Out == $past(aIn)));
  a_r3_wide_hold: assert property (@(posedge clk) disable iff (rst)
    !strobe.ldWide |=> ($stable(b1Out) && $stable(b2Out)));

  // R5: capture registers hold without their enable
  a_r5_cap_hold: assert property (@(posedge clk) disable iff (rst)
    (!strobe.ldA1 && !strobe.ldA2) |=> ($stable(capQ[0]) && $stable(capQ[1])));

  // R1: reset clears the wide outputs
  a_r1_reset_clear: assert property (@(posedge clk) rst |=> (b1Out == '0 && b2Out == '0));

endmodule

// File: rtl/nw_bus_exchanger.sv
module nw_bus_exchanger
  import xch_pkg::*;
#(
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] aIn,
  input  logic [WORD_W-1:0] b1In,
  input  logic [WORD_W-1:0] b2In,
  input  logic              ceB1Neg,
  input  logic              ceB2Neg,
  input  logic              ceA1Neg,
  input  logic              ceA2Neg,
  input  logic              selB2,
  input  logic              oeANeg,
  input  logic              oeBNeg,
  output logic [WORD_W-1:0] aOut,
  output logic              aDrive,
  output logic [WORD_W-1:0] b1Out,
  output logic [WORD_W-1:0] b2Out,
  output logic              bDrive
);

  xch_strobe_t strobe;

  xch_ctrl uCtrl (
    .clk(clk), .rst(rst),
    .ceB1Neg(ceB1Neg), .ceB2Neg(ceB2Neg), .ceA1Neg(ceA1Neg), .ceA2Neg(ceA2Neg),
    .selB2(selB2), .oeANeg(oeANeg), .oeBNeg(oeBNeg),
    .strobe(strobe)
  );

  xch_datapath #(.WORD_W(WORD_W)) uData (
    .clk(clk), .rst(rst), .strobe(strobe),
    .aIn(aIn), .b1In(b1In), .b2In(b2In),
    .aOut(aOut), .b1Out(b1Out), .b2Out(b2Out)
  );

  assign aDrive = strobe.driveA;
  assign bDrive = strobe.driveB;

endmodule

// File: tb/sim_nw_bus_exchanger.sv
module sim_nw_bus_exchanger;

  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] aIn, b1In, b2In;
  logic         ceB1Neg, ceB2Neg, ceA1Neg, ceA2Neg, selB2, oeANeg, oeBNeg;
  logic [W-1:0] aOut, b1Out, b2Out;
  logic         aDrive, bDrive;

  int checks = 0;
  int errors = 0;

  // Reference state, written from the requirements
  logic [W-1:0] mFront, mB1, mB2, mA1, mA2;
  logic         mSel, mOeA, mOeB;

  always #2.5 clk = ~clk;

  nw_bus_exchanger #(.WORD_W(W)) u0 (
    .clk(clk), .rst(rst), .aIn(aIn), .b1In(b1In), .b2In(b2In),
    .ceB1Neg(ceB1Neg), .ceB2Neg(ceB2Neg), .ceA1Neg(ceA1Neg), .ceA2Neg(ceA2Neg),
    .selB2(selB2), .oeANeg(oeANeg), .oeBNeg(oeBNeg),
    .aOut(aOut), .aDrive(aDrive), .b1Out(b1Out), .b2Out(b2Out), .bDrive(bDrive)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Advance one edge, update the model, sample at the falling edge
  task automatic tick();
    logic [W-1:0] oldFront;
    oldFront = mFront;
    if (rst) begin
      mFront = '0; mB1 = '0; mB2 = '0; mA1 = '0; mA2 = '0;
      mSel = 1'b0; mOeA = 1'b1; mOeB = 1'b1;
    end else begin
      if (!ceB1Neg) mFront = aIn;
      if (!ceB2Neg) begin mB1 = oldFront; mB2 = aIn; end
      if (!ceA1Neg) mA1 = b1In;
      if (!ceA2Neg) mA2 = b2In;
      mSel = selB2; mOeA = oeANeg; mOeB = oeBNeg;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic checkAll();
    chk("R2/R3 b1Out", b1Out, mB1);
    chk("R3 b2Out", b2Out, mB2);
    chk("R5/R6 aOut", aOut, mSel ? mA2 : mA1);
    chk("R7 aDrive", {11'd0, aDrive}, {11'd0, !mOeA});
    chk("R7 bDrive", {11'd0, bDrive}, {11'd0, !mOeB});
  endtask

  task automatic idle();
    ceB1Neg = 1; ceB2Neg = 1; ceA1Neg = 1; ceA2Neg = 1;
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1; aIn = 12'hABC; b1In = 12'h123; b2In = 12'h456;
    ceB1Neg = 0; ceB2Neg = 0; ceA1Neg = 0; ceA2Neg = 0;
    selB2 = 0; oeANeg = 0; oeBNeg = 0;
    @(negedge clk);
    tick(); tick();
    // R1: reset state
    chk("R1 b1Out", b1Out, '0);
    chk("R1 b2Out", b2Out, '0);
    chk("R1 aOut", aOut, '0);
    chk("R1 aDrive", {11'd0, aDrive}, '0);
    chk("R1 bDrive", {11'd0, bDrive}, '0);
    rst = 0; idle(); selB2 = 1; oeANeg = 1; oeBNeg = 1;
    tick();
    chk("R1 aOut sel1", aOut, '0);
    checkAll();

    // R4: pairing sequence
    ceB1Neg = 0; aIn = 12'h5A1;
    tick();
    idle(); ceB2Neg = 0; aIn = 12'h3C2;
    tick();
    chk("R4 b1Out pair", b1Out, 12'h5A1);
    chk("R4 b2Out pair", b2Out, 12'h3C2);
    checkAll();

    // R6: select change between edges has no effect until the edge
    idle(); ceA1Neg = 0; ceA2Neg = 0; b1In = 12'h111; b2In = 12'h222; selB2 = 0;
    tick();
    idle();
    chk("R6 aOut sel0", aOut, 12'h111);
    selB2 = 1;
    #1;
    chk("R6 aOut before edge", aOut, 12'h111);
    tick();
    chk("R6 aOut sel1", aOut, 12'h222);

    // R8: drive off keeps data visible
    oeANeg = 1; oeBNeg = 1;
    tick();
    chk("R8 aOut while off", aOut, 12'h222);
    chk("R8 b1Out while off", b1Out, 12'h5A1);
    chk("R8 bDrive off", {11'd0, bDrive}, '0);

    // Sweep: all enable combinations with varying data and controls
    for (int i = 0; i < 512; i++) begin
      ceB1Neg = i[0]; ceB2Neg = i[1]; ceA1Neg = i[2]; ceA2Neg = i[3];
      selB2 = i[4] ^ i[6]; oeANeg = i[5]; oeBNeg = i[7] ^ i[2];
      aIn  = W'((i * 1237 + 91) & 12'hFFF);
      b1In = W'((i * 733 + 17) & 12'hFFF);
      b2In = W'((i * 2011 + 5) & 12'hFFF);
      rst  = (i == 300);
      tick();
      checkAll();
      if (i == 300) begin
        chk("R1 mid reset b1Out", b1Out, '0);
        chk("R1 mid reset aDrive", {11'd0, aDrive}, '0);
      end
    end
    rst = 0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule